// File: doc/BRIEF.md
# Run-Length Port-Select Sequencer

This block drives the port-select lines of a read or write unit from a pair of small constant tables. It does not evaluate a guard expression at each iteration. The pattern table holds one select vector per entry, with one bit per port. The repeat table holds, for each entry, how many extra times that vector is reused before the sequencer moves on. Together the two tables describe the whole iteration domain in run-length form. The storage is (entries × ports) + (entries × count width) bits, instead of ports × domain-size bits for a flat per-iteration table.

A `start` pulse launches a pass over the domain. The select words leave on a valid/ready stream, one word per iteration. A word is consumed only on a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low the word on `out_sel` and `out_valid` are held. The sequencer may not withdraw or change a word it has offered. The final word of the final entry is accepted, and on the next cycle the stream closes and `done` rises. `done` stays high until the next `start`. The tables are parameters and are fixed when the block is built.

Top module: `rle_select_seq`

## Requirements
- R1: After reset, `out_valid` and `done` are both low.
- R2: A `start` pulse while `out_valid` is low makes `out_valid` high on the next cycle, with `out_sel` equal to pattern entry 0 and `done` low.
- R3: Pattern entry i sits at bits [i*NUM_PORTS +: NUM_PORTS] of `SEL_TABLE`, and bit p of an entry selects port p. Its repeat count k sits at bits [i*CNT_W +: CNT_W] of `RPT_TABLE`. Entry i is accepted exactly k+1 times in a row, and entries are sent in ascending index order.
- R4: From launch until the last word is accepted, `out_valid` stays high on every cycle. There is no bubble between entries, and `out_valid` falls only when `done` rises.
- R5: While `out_valid` is high and `out_ready` is low, the next cycle still shows `out_valid` high with an unchanged `out_sel`.
- R6: One cycle after the last word is accepted, `done` is high and `out_valid` is low. `done` then holds until `start`.
- R7: A `start` pulse while `out_valid` is high is ignored, and the stream continues unchanged.
- R8: A `start` pulse after `done` replays the complete sequence from entry 0.
- R9: With every repeat count zero, the stream holds exactly one word per entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launches a pass when no stream is active |
| out_ready | input | 1 | Downstream accepts the current select word |
| out_valid | output | 1 | A select word is offered |
| out_sel | output | NUM_PORTS | Select vector, bit p selects port p |
| done | output | 1 | The pass is finished, held until the next start |

## Verification
The bench builds three copies side by side, each with its own start and ready lines.
- The first uses the default parameters: two ports, two entries, each repeated four extra times. This gives the plain five-then-five split.
- The second uses four ports and five entries with counts 0, 7, 2, 5 and 1. It includes the largest count a 3-bit field can hold, a single-word entry next to long runs, and enough length to inject a start pulse in mid-stream.
- The third uses three ports, four entries and a 2-bit count field that is all zero. This is the case where every entry is sent once and the entry index advances on every accepted word.

All three streams run under random back-pressure and are then replayed.

// File: rtl/rle_seq_pkg.sv
package rle_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/rle_table_rom.sv
module rle_table_rom #(
  parameter int NUM_PORTS   = 2,
  parameter int NUM_ENTRIES = 2,
  parameter int CNT_W       = 3,
  parameter int IDX_W       = 1,
  parameter logic [NUM_ENTRIES*NUM_PORTS-1:0] SEL_TABLE = '0,
  parameter logic [NUM_ENTRIES*CNT_W-1:0]     RPT_TABLE = '0
) (
  input  logic [IDX_W-1:0]     sel_idx,
  input  logic [IDX_W-1:0]     load_idx,
  output logic [NUM_PORTS-1:0] sel_word,
  output logic [CNT_W-1:0]     rpt_word
);
  logic [NUM_PORTS-1:0] sel_arr [NUM_ENTRIES];
  logic [CNT_W-1:0]     rpt_arr [NUM_ENTRIES];

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
    assign sel_arr[g] = SEL_TABLE[g*NUM_PORTS +: NUM_PORTS];
    assign rpt_arr[g] = RPT_TABLE[g*CNT_W +: CNT_W];
  end

  // Index decode per entry; an index past the table reads as zero.
  always_comb begin
    sel_word = '0;
    rpt_word = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (sel_idx == IDX_W'(i))  sel_word = sel_arr[i];
      if (load_idx == IDX_W'(i)) rpt_word = rpt_arr[i];
    end
  end
endmodule

// File: rtl/rle_repeat_counter.sv
module rle_repeat_counter #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);
  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    remain_q <= '0;
    else if (load) remain_q <= load_val;
    else if (dec)  remain_q <= remain_q - 1'b1;
  end

  assign last = (remain_q == '0);
endmodule

// File: rtl/rle_seq_ctrl.sv
module rle_seq_ctrl
  import rle_seq_pkg::*;
#(
  parameter int NUM_ENTRIES = 2,
  parameter int IDX_W       = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             out_ready,
  input  logic             cnt_last,
  output logic             out_valid,
  output logic             done,
  output logic             cnt_load,
  output logic             cnt_dec,
  output logic [IDX_W-1:0] cur_idx,
  output logic [IDX_W-1:0] load_idx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

  seq_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic             running, accept, launch, idx_last, step_entry, finish;

  always_comb begin
    running    = (state_q == ST_RUN);
    accept     = running && out_ready;
    launch     = start && !running;
    idx_last   = (idx_q == LAST_IDX);
    step_entry = accept && cnt_last && !idx_last;
    finish     = accept && cnt_last && idx_last;
    cnt_load   = launch || step_entry;
    cnt_dec    = accept && !cnt_last;
    load_idx   = launch ? '0 : IDX_W'(idx_q + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      if (launch)      state_q <= ST_RUN;
      else if (finish) state_q <= ST_DONE;
      if (launch)          idx_q <= '0;
      else if (step_entry) idx_q <= load_idx;
    end
  end

  assign out_valid = running;
  assign done      = (state_q == ST_DONE);
  assign cur_idx   = idx_q;
endmodule

// File: rtl/rle_select_seq.sv
module rle_select_seq #(
  parameter int NUM_PORTS   = 2,
  parameter int NUM_ENTRIES = 2,
  parameter int CNT_W       = 3,
  parameter logic [NUM_ENTRIES*NUM_PORTS-1:0] SEL_TABLE = {2'b10, 2'b01},
  parameter logic [NUM_ENTRIES*CNT_W-1:0]     RPT_TABLE = {3'd4, 3'd4}
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 out_ready,
  output logic                 out_valid,
  output logic [NUM_PORTS-1:0] out_sel,
  output logic                 done
);
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  logic             cnt_last, cnt_load, cnt_dec;
  logic [IDX_W-1:0] cur_idx, load_idx;
  logic [CNT_W-1:0] rpt_word;

  rle_seq_ctrl #(
    .NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .out_ready(out_ready),
    .cnt_last(cnt_last), .out_valid(out_valid), .done(done),
    .cnt_load(cnt_load), .cnt_dec(cnt_dec),
    .cur_idx(cur_idx), .load_idx(load_idx)
  );

  rle_table_rom #(
    .NUM_PORTS(NUM_PORTS), .NUM_ENTRIES(NUM_ENTRIES), .CNT_W(CNT_W),
    .IDX_W(IDX_W), .SEL_TABLE(SEL_TABLE), .RPT_TABLE(RPT_TABLE)
  ) i_rom (
    .sel_idx(cur_idx), .load_idx(load_idx),
    .sel_word(out_sel), .rpt_word(rpt_word)
  );

  rle_repeat_counter #(
    .CNT_W(CNT_W)
  ) i_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(rpt_word),
    .dec(cnt_dec), .last(cnt_last)
  );
endmodule

// File: rtl/rle_select_seq_chk.sv
module rle_select_seq_chk #(
  parameter int NUM_PORTS = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 out_ready,
  input logic                 out_valid,
  input logic [NUM_PORTS-1:0] out_sel,
  input logic                 done
);
  a_r2_start_launches: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && start) |=> (out_valid && !done));

  a_r4_no_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> done);

  a_r5_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sel)));

  a_r6_done_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && done));

  a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  a_r7_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && start) |=> (out_valid && $stable(out_sel)));
endmodule

bind rle_select_seq rle_select_seq_chk #(.NUM_PORTS(NUM_PORTS)) i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .out_ready(out_ready),
  .out_valid(out_valid), .out_sel(out_sel), .done(done)
);

// File: tb/test_rle_select_seq.sv
module test_rle_select_seq;
  localparam logic [3:0]  A_SEL = {2'b10, 2'b01};
  localparam logic [5:0]  A_RPT = {3'd4, 3'd4};
  localparam logic [19:0] B_SEL = {4'b0100, 4'b1111, 4'b1000, 4'b0110, 4'b0001};
  localparam logic [14:0] B_RPT = {3'd1, 3'd5, 3'd2, 3'd7, 3'd0};
  localparam logic [11:0] C_SEL = {3'b011, 3'b100, 3'b010, 3'b001};
  localparam logic [7:0]  C_RPT = 8'h00;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] st = '0;
  logic [2:0] rdy = '0;
  logic [2:0] ov, od;
  logic [1:0] sel_a;
  logic [3:0] sel_b;
  logic [2:0] sel_c;
  logic [7:0] osel [3];

  always #5 clk = ~clk;

  rle_select_seq i_rle_select_seq (
    .clk(clk), .rst_n(rst_n), .start(st[0]), .out_ready(rdy[0]),
    .out_valid(ov[0]), .out_sel(sel_a), .done(od[0]));

  rle_select_seq #(.NUM_PORTS(4), .NUM_ENTRIES(5), .CNT_W(3),
    .SEL_TABLE(B_SEL), .RPT_TABLE(B_RPT)) i_rle_select_seq_b (
    .clk(clk), .rst_n(rst_n), .start(st[1]), .out_ready(rdy[1]),
    .out_valid(ov[1]), .out_sel(sel_b), .done(od[1]));

  rle_select_seq #(.NUM_PORTS(3), .NUM_ENTRIES(4), .CNT_W(2),
    .SEL_TABLE(C_SEL), .RPT_TABLE(C_RPT)) i_rle_select_seq_c (
    .clk(clk), .rst_n(rst_n), .start(st[2]), .out_ready(rdy[2]),
    .out_valid(ov[2]), .out_sel(sel_c), .done(od[2]));

  assign osel[0] = {6'd0, sel_a};
  assign osel[1] = {4'd0, sel_b};
  assign osel[2] = {5'd0, sel_c};

  int np [3] = '{2, 4, 3};
  int ne [3] = '{2, 5, 4};
  int cw [3] = '{3, 3, 2};
  logic [63:0] selt [3] = '{64'(A_SEL), 64'(B_SEL), 64'(C_SEL)};
  logic [63:0] rptt [3] = '{64'(A_RPT), 64'(B_RPT), 64'(C_RPT)};

  int n_tests = 0;
  int n_fail = 0;
  int got [3];
  int total [3];
  bit running [3], arm [3], stall [3], fin_pend [3], finished [3];
  logic [7:0] held [3];

  function automatic logic [7:0] exp_word(input int id, input int k);
    int pos = 0;
    logic [7:0] w = '0;
    for (int e = 0; e < ne[id]; e++) begin
      int reps = int'((rptt[id] >> (e*cw[id])) & ((64'd1 << cw[id]) - 1)) + 1;
      if (k >= pos && k < pos + reps)
        w = 8'((selt[id] >> (e*np[id])) & ((64'd1 << np[id]) - 1));
      pos += reps;
    end
    return w;
  endfunction

  function automatic int exp_total(input int id);
    int t = 0;
    for (int e = 0; e < ne[id]; e++)
      t += int'((rptt[id] >> (e*cw[id])) & ((64'd1 << cw[id]) - 1)) + 1;
    return t;
  endfunction

  task automatic chk(input bit ok, input string req, input int id,
                     input logic [31:0] act, input logic [31:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s inst=%0d actual=%0h expected=%0h", req, id, act, expv);
    end
  endtask

  // One cycle: drive at the falling edge, sample 1 ns later.
  task automatic step(input logic [2:0] start_mask);
    @(negedge clk);
    st = start_mask;
    for (int i = 0; i < 3; i++) rdy[i] = (($urandom % 4) != 0);
    #1;
    for (int i = 0; i < 3; i++) begin
      if (arm[i]) begin
        chk(ov[i] && !od[i] && osel[i] == exp_word(i, 0), "R2", i,
            {ov[i], od[i], osel[i]}, {2'b10, exp_word(i, 0)});
        running[i] = 1'b1;
        arm[i] = 1'b0;
      end
      if (fin_pend[i]) begin
        chk(od[i] && !ov[i], (i == 2) ? "R6/R9" : "R6", i, {od[i], ov[i]}, 2'b10);
        fin_pend[i] = 1'b0;
        finished[i] = 1'b1;
      end
      if (stall[i])
        chk(ov[i] && osel[i] == held[i], "R5", i, {ov[i], osel[i]}, {1'b1, held[i]});
      if (running[i]) begin
        chk(ov[i] == 1'b1, "R4", i, ov[i], 1);
        if (ov[i] && rdy[i]) begin
          chk(osel[i] == exp_word(i, got[i]), (i == 2) ? "R3/R9" : "R3", i,
              osel[i], exp_word(i, got[i]));
          got[i]++;
          if (got[i] == total[i]) begin
            running[i] = 1'b0;
            fin_pend[i] = 1'b1;
          end
        end
      end
      stall[i] = ov[i] && !rdy[i];
      held[i] = osel[i];
      if (start_mask[i] && !running[i] && !arm[i] && !fin_pend[i]) begin
        arm[i] = 1'b1;
        got[i] = 0;
        finished[i] = 1'b0;
      end
    end
  endtask

  task automatic run_pass(input string req);
    int cyc = 0;
    step(3'b111);
    while (!(finished[0] && finished[1] && finished[2])) begin
      cyc++;
      // R7: a start into the running stream of instance 1 must be ignored.
      step((cyc == 6) ? 3'b010 : 3'b000);
      if (cyc > 600) begin
        chk(1'b0, {req, " watchdog"}, 0, cyc, 600);
        break;
      end
    end
    for (int i = 0; i < 3; i++)
      chk(got[i] == total[i], req, i, got[i], total[i]);
    for (int j = 0; j < 3; j++) begin
      step(3'b000);
      for (int i = 0; i < 3; i++)
        chk(od[i] && !ov[i], "R6 hold", i, {od[i], ov[i]}, 2'b10);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 3; i++) total[i] = exp_total(i);
    repeat (3) @(negedge clk);
    #1;
    for (int i = 0; i < 3; i++)
      chk(!ov[i] && !od[i], "R1", i, {ov[i], od[i]}, 0);
    rst_n = 1'b1;
    step(3'b000);
    for (int i = 0; i < 3; i++)
      chk(!ov[i] && !od[i], "R1", i, {ov[i], od[i]}, 0);
    run_pass("R3 R7 pass1");
    run_pass("R8 replay");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule